// File: doc/BRIEF.md
# Frame-Synchronised Serial Converter Port

This block is a serial port for a converter that talks directly to a signal processor's synchronous serial port, with the processor supplying the bit clock. All of its logic runs on one system clock. The serial clock, chip select and incoming sync line are sampled into that clock domain, and their edges are detected there.

A falling chip select with the incoming sync line low selects this port. Chip select may then stay low across any number of conversions. Each conversion begins when an incoming sync pulse falls. The port then:

- takes the command word from the data input on falling serial-clock edges;
- reports the selected channel and the start of acquisition;
- raises a sample strobe for the converter core;
- sends a one-clock outgoing sync pulse;
- shifts the result frame out on rising serial-clock edges.

An 8-bit or a 16-bit word width is chosen per conversion.

A new incoming sync pulse restarts the port at any point in a conversion. A rising chip select cancels the conversion and leaves the port idle.

Top module: `dsp_fsync_port`

## Requirements
- R1: After reset, `dsp_mode`, `dout`, `fsync_out` and all strobes are low, and `cmd_word` and `chan_sel` are zero.
- R2: On a falling `cs_n`, the port enters frame mode (`dsp_mode`=1) only if `fsync_in` is low at that moment. If `fsync_in` is high, `dsp_mode` stays 0, and sync pulses and serial clocks then produce no strobe and no `fsync_out`.
- R3: After `fsync_in` falls in frame mode, the data input is taken on falling `sclk` edges. The first 8 bits, first bit in the MSB, form `cmd_word`. `cmd_stb` pulses on the 8th falling edge in 8-bit width (`wide_sel`=0 when the sync falls) or on the 16th in 16-bit width (`wide_sel`=1). Bits 9 to 16 in 16-bit width leave `cmd_word` unchanged.
- R4: On the 3rd falling edge, `acq_stb` pulses once and `chan_sel` takes the first three command bits, so `chan_sel` equals `cmd_word[7:5]`.
- R5: `sample_stb` pulses exactly once per conversion, at the rising edge of clock 7 (8-bit) or clock 15 (16-bit). Clock k is the rising edge that follows the k-th falling edge.
- R6: `fsync_out` is high from the rising edge of clock 8 (16-bit: 16) up to the next rising edge, and low at all other times.
- R7: On the rising edges of clocks 9 to 24 (16-bit: 17 to 32), `dout` carries the frame `{result_in, 2'b00}`, MSB first. `result_in` is taken at the rising edge that raises `fsync_out`.
- R8: After the 16 frame bits, further rising edges drive `dout` to 0 until the next sync pulse.
- R9: A falling `fsync_in` during a conversion clears `dout` and `fsync_out` and restarts counting from clock 0. The new conversion then behaves as in R3 to R8.
- R10: A rising `cs_n` cancels the conversion and clears `dsp_mode`, `dout` and `fsync_out`. After that, clocks and sync pulses have no effect until `cs_n` falls again with `fsync_in` low and a new sync pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| fsync_in | input | 1 | Incoming frame sync; a falling edge starts a conversion |
| sclk | input | 1 | Serial bit clock from the processor, idle high |
| din | input | 1 | Serial command data |
| wide_sel | input | 1 | 1 selects 16-bit word width, taken when the sync falls |
| result_in | input | 14 | Conversion result from the converter core |
| dsp_mode | output | 1 | Frame-synchronised mode active |
| cmd_word | output | 8 | Captured command byte |
| cmd_stb | output | 1 | One-cycle pulse when command capture ends |
| chan_sel | output | 3 | Selected channel |
| acq_stb | output | 1 | One-cycle pulse at start of acquisition |
| sample_stb | output | 1 | One-cycle pulse at the sampling instant |
| fsync_out | output | 1 | Outgoing frame-sync pulse |
| dout | output | 1 | Serial result data |

## Verification
The main sweep covers all eight channel codes in both word widths, each with its own result pattern. Because every run differs in channel, result bits and framing, a strobe or output bit that lands one clock too early or too late, or is taken from the wrong position, produces a mismatch. In 16-bit runs the filler bits are driven as a toggling pattern, which exposes capture that goes on past the eighth bit. Restarts are tried both before the sampling point and in the middle of the output shift, which separates a proper reset of the counters from one that leaves the shifter running. Chip-select aborts are followed by clocks and sync pulses both with chip select high and after it returns low without a new sync, to show that the port stays idle until it is properly re-entered.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  // positions of the sampled control lines inside the synchroniser vector
  localparam int IX_SCLK = 0;
  localparam int IX_CS   = 1;
  localparam int IX_FS   = 2;
  localparam int N_SYNC  = 3;
  // reset levels: serial clock idles high, chip select inactive high, sync low
  localparam logic [N_SYNC-1:0] SYNC_RST = 3'b011;
endpackage

// File: rtl/dfs_edge.sv
module dfs_edge #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl[i] <= RST_VAL[i];
        prv[i] <= RST_VAL[i];
      end else begin
        lvl[i] <= d[i];
        prv[i] <= lvl[i];
      end
    end
  end
endmodule

// File: rtl/dfs_rx.sv
module dfs_rx #(
  parameter int CMD_W    = 8,
  parameter int CH_W     = 3,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_lvl,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             fs_lvl,
  input  logic             fs_fall,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             din_lvl,
  input  logic             wide_sel,
  output logic             dsp_mode,
  output logic             armed,
  output logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] wlen,
  output logic [CMD_W-1:0] cmd_word,
  output logic             cmd_stb,
  output logic [CH_W-1:0]  chan_sel,
  output logic             acq_stb,
  output logic             sample_stb
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CMD_N   = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CH_LAST = CNT_W'(CH_W - 1);
  localparam logic [CNT_W-1:0] LEN_N   = CNT_W'(NARROW_W);
  localparam logic [CNT_W-1:0] LEN_W   = CNT_W'(WIDE_W);

  logic             wide;
  logic [CMD_W-1:0] cmd_sr;
  logic [CMD_W-1:0] cmd_next;

  function automatic logic [CNT_W-1:0] word_len(input logic w);
    return w ? LEN_W : LEN_N;
  endfunction

  assign wlen     = word_len(wide);
  assign restart  = fs_fall & dsp_mode & ~cs_lvl & ~cs_rise;
  assign cmd_next = (cnt < CMD_N) ? {cmd_sr[CMD_W-2:0], din_lvl} : cmd_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsp_mode   <= 1'b0;
      armed      <= 1'b0;
      wide       <= 1'b0;
      cnt        <= '0;
      cmd_sr     <= '0;
      cmd_word   <= '0;
      chan_sel   <= '0;
      cmd_stb    <= 1'b0;
      acq_stb    <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      cmd_stb    <= 1'b0;
      acq_stb    <= 1'b0;
      sample_stb <= 1'b0;
      if (cs_rise) begin
        dsp_mode <= 1'b0;
        armed    <= 1'b0;
        cnt      <= '0;
      end else if (cs_fall) begin
        dsp_mode <= ~fs_lvl;
        armed    <= 1'b0;
        cnt      <= '0;
      end else if (restart) begin
        armed  <= 1'b1;
        wide   <= wide_sel;
        cnt    <= '0;
        cmd_sr <= '0;
      end else if (armed) begin
        if (sclk_fall) begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          cmd_sr <= cmd_next;
          if (cnt == CH_LAST) begin
            acq_stb  <= 1'b1;
            chan_sel <= cmd_next[CH_W-1:0];
          end
          if (cnt == wlen - 1'b1) begin
            cmd_stb  <= 1'b1;
            cmd_word <= cmd_next;
          end
        end
        if (sclk_rise && cnt == wlen - 1'b1) sample_stb <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dfs_tx.sv
module dfs_tx #(
  parameter int DATA_W  = 14,
  parameter int STAT_W  = 2,
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              restart,
  input  logic              armed,
  input  logic              sclk_rise,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  wlen,
  input  logic [DATA_W-1:0] result_in,
  output logic              fsync_out,
  output logic              dout
);
  logic [FRAME_W-1:0] osr;

  function automatic logic [FRAME_W-1:0] pack_frame(input logic [DATA_W-1:0] d);
    return {d, {STAT_W{1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsync_out <= 1'b0;
      dout      <= 1'b0;
      osr       <= '0;
    end else if (kill || restart) begin
      fsync_out <= 1'b0;
      dout      <= 1'b0;
      osr       <= '0;
    end else if (armed && sclk_rise) begin
      fsync_out <= (cnt == wlen);
      if (cnt == wlen) osr <= pack_frame(result_in);
      if (cnt > wlen) begin
        dout <= osr[FRAME_W-1];
        osr  <= {osr[FRAME_W-2:0], 1'b0};
      end else begin
        dout <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsp_fsync_port.sv
module dsp_fsync_port #(
  parameter int DATA_W   = 14,
  parameter int STAT_W   = 2,
  parameter int CMD_W    = 8,
  parameter int CH_W     = 3,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              fsync_in,
  input  logic              sclk,
  input  logic              din,
  input  logic              wide_sel,
  input  logic [DATA_W-1:0] result_in,
  output logic              dsp_mode,
  output logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_stb,
  output logic [CH_W-1:0]   chan_sel,
  output logic              acq_stb,
  output logic              sample_stb,
  output logic              fsync_out,
  output logic              dout
);
  import dfs_pkg::*;

  localparam int FRAME_W = DATA_W + STAT_W;
  localparam int CNT_W   = $clog2(WIDE_W + FRAME_W + 1) + 1;

  logic [N_SYNC-1:0] line_lvl, line_prv;
  logic              din_r;
  logic              sclk_rise_ev, sclk_fall_ev;
  logic              cs_rise_ev, cs_fall_ev, sync_fall_ev;
  logic              restart_ev, armed;
  logic [CNT_W-1:0]  cnt, wlen;

  dfs_edge #(.N(N_SYNC), .RST_VAL(SYNC_RST)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .d({fsync_in, cs_n, sclk}),
    .lvl(line_lvl), .prv(line_prv)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) din_r <= 1'b0;
    else        din_r <= din;
  end

  assign sclk_rise_ev = line_lvl[IX_SCLK] & ~line_prv[IX_SCLK];
  assign sclk_fall_ev = ~line_lvl[IX_SCLK] & line_prv[IX_SCLK];
  assign cs_rise_ev   = line_lvl[IX_CS] & ~line_prv[IX_CS];
  assign cs_fall_ev   = ~line_lvl[IX_CS] & line_prv[IX_CS];
  assign sync_fall_ev = ~line_lvl[IX_FS] & line_prv[IX_FS];

  dfs_rx #(.CMD_W(CMD_W), .CH_W(CH_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W),
           .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_lvl(line_lvl[IX_CS]), .cs_fall(cs_fall_ev), .cs_rise(cs_rise_ev),
    .fs_lvl(line_lvl[IX_FS]), .fs_fall(sync_fall_ev),
    .sclk_rise(sclk_rise_ev), .sclk_fall(sclk_fall_ev),
    .din_lvl(din_r), .wide_sel(wide_sel),
    .dsp_mode(dsp_mode), .armed(armed), .restart(restart_ev),
    .cnt(cnt), .wlen(wlen),
    .cmd_word(cmd_word), .cmd_stb(cmd_stb),
    .chan_sel(chan_sel), .acq_stb(acq_stb), .sample_stb(sample_stb)
  );

  dfs_tx #(.DATA_W(DATA_W), .STAT_W(STAT_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .kill(cs_rise_ev | cs_fall_ev), .restart(restart_ev),
    .armed(armed), .sclk_rise(sclk_rise_ev),
    .cnt(cnt), .wlen(wlen), .result_in(result_in),
    .fsync_out(fsync_out), .dout(dout)
  );
endmodule

// File: rtl/dfs_chk.sv
module dfs_chk #(
  parameter int CMD_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk_rise_ev,
  input logic             sclk_fall_ev,
  input logic             cs_rise_ev,
  input logic             cs_fall_ev,
  input logic             restart_ev,
  input logic             dsp_mode,
  input logic [CMD_W-1:0] cmd_word,
  input logic             cmd_stb,
  input logic             acq_stb,
  input logic             sample_stb,
  input logic             fsync_out,
  input logic             dout
);
  // R2
  sample_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> dsp_mode);

  // R3
  cmd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_word) |-> $past(sclk_fall_ev));

  // R4
  acq_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_stb |-> $past(sclk_fall_ev));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acq_stb, cmd_stb, sample_stb}));

  // R6
  fs_rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_out) |-> $past(sclk_rise_ev));

  // R7
  dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(sclk_rise_ev | restart_ev | cs_rise_ev | cs_fall_ev));

  // R10
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_ev |=> (!dsp_mode && !fsync_out && !dout));
endmodule

bind dsp_fsync_port dfs_chk #(.CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sclk_rise_ev(sclk_rise_ev), .sclk_fall_ev(sclk_fall_ev),
  .cs_rise_ev(cs_rise_ev), .cs_fall_ev(cs_fall_ev), .restart_ev(restart_ev),
  .dsp_mode(dsp_mode), .cmd_word(cmd_word), .cmd_stb(cmd_stb),
  .acq_stb(acq_stb), .sample_stb(sample_stb),
  .fsync_out(fsync_out), .dout(dout)
);

// File: tb/dsp_fsync_port_tb.sv
`timescale 1ns/1ps
module dsp_fsync_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, fsync_in = 1'b0, sclk = 1'b1, din = 1'b0, wide_sel = 1'b0;
  logic [13:0] result_in = '0;
  logic dsp_mode, cmd_stb, acq_stb, sample_stb, fsync_out, dout;
  logic [7:0] cmd_word;
  logic [2:0] chan_sel;

  int checks = 0, errors = 0;
  int nfall = 0, nrise = 0;
  int acq_cnt = 0, acq_at = 0, samp_cnt = 0, samp_at = 0, cmd_cnt = 0;
  logic [2:0] acq_ch = '0;
  logic [63:0] got_dout = '0, got_fs = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dsp_fsync_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fsync_in(fsync_in), .sclk(sclk),
    .din(din), .wide_sel(wide_sel), .result_in(result_in),
    .dsp_mode(dsp_mode), .cmd_word(cmd_word), .cmd_stb(cmd_stb),
    .chan_sel(chan_sel), .acq_stb(acq_stb), .sample_stb(sample_stb),
    .fsync_out(fsync_out), .dout(dout)
  );

  always @(negedge clk) begin
    if (acq_stb) begin acq_cnt++; acq_at = nfall; acq_ch = chan_sel; end
    if (sample_stb) begin samp_cnt++; samp_at = nrise; end
    if (cmd_stb) cmd_cnt++;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_obs();
    nfall = 0; nrise = 0; acq_cnt = 0; samp_cnt = 0; cmd_cnt = 0;
    acq_at = 0; samp_at = 0; got_dout = '0; got_fs = '0;
  endtask

  task automatic send_sync(input bit w16);
    wide_sel = w16;
    fsync_in = 1'b1;
    repeat (6) @(negedge clk);
    fsync_in = 1'b0;
    repeat (4) @(negedge clk);
    clear_obs();
  endtask

  task automatic one_clock(input logic b);
    din = b;
    repeat (2) @(negedge clk);
    sclk = 1'b0; nfall++;
    repeat (4) @(negedge clk);
    sclk = 1'b1; nrise++;
    repeat (3) @(negedge clk);
    got_dout[nrise] = dout;
    got_fs[nrise]   = fsync_out;
    repeat (1) @(negedge clk);
  endtask

  function automatic logic cmd_bit(input logic [7:0] c, input int k);
    return (k <= 8) ? c[8-k] : logic'(k % 2);
  endfunction

  task automatic run_clocks(input logic [7:0] c, input int n);
    for (int k = 1; k <= n; k++) one_clock(cmd_bit(c, k));
  endtask

  task automatic full_frame(input bit w16, input logic [7:0] c, input logic [13:0] res);
    int w;
    int n;
    logic [63:0] exp_d, mask_data, mask_tail;
    w = w16 ? 16 : 8;
    n = w + 16 + 4;
    result_in = res;
    send_sync(w16);
    run_clocks(c, n);
    exp_d = '0; mask_data = '0; mask_tail = '0;
    for (int k = 1; k <= n; k++) begin
      if (k > w && k <= w + 16) begin
        mask_data[k] = 1'b1;
        exp_d[k] = (k - w - 1 < 14) ? res[13 - (k - w - 1)] : 1'b0;
      end else if (k > w + 16) begin
        mask_tail[k] = 1'b1;
      end
    end
    check(cmd_cnt == 1 && cmd_word == c, "R3 command capture", longint'(cmd_word), longint'(c));
    check(acq_cnt == 1 && acq_at == 3 && acq_ch == c[7:5], "R4 channel at third fall",
          longint'({acq_at, 5'(acq_cnt), acq_ch}), longint'({32'd3, 5'd1, c[7:5]}));
    check(samp_cnt == 1 && samp_at == w - 1, "R5 sample strobe clock",
          longint'(samp_at), longint'(w - 1));
    check(got_fs == (64'd1 << w), "R6 outgoing sync", longint'(got_fs), longint'(64'd1 << w));
    check((got_dout & mask_data) == exp_d, "R7 result bits",
          longint'(got_dout & mask_data), longint'(exp_d));
    check((got_dout & mask_tail) == '0, "R8 trailing zeros", longint'(got_dout & mask_tail), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(!dsp_mode && !dout && !fsync_out && !acq_stb && !sample_stb && !cmd_stb &&
          cmd_word == 0 && chan_sel == 0, "R1 reset state",
          longint'({dsp_mode, dout, fsync_out, cmd_word, chan_sel}), 0);

    // R2 sync high at chip-select fall: port stays out of frame mode
    fsync_in = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    check(!dsp_mode, "R2 sync high keeps port idle", longint'(dsp_mode), 0);
    fsync_in = 1'b0;
    repeat (4) @(negedge clk);
    clear_obs();
    run_clocks(8'hE5, 24);
    check(acq_cnt + samp_cnt + cmd_cnt == 0 && got_fs == 0, "R2 no activity outside frame mode",
          longint'(acq_cnt + samp_cnt + cmd_cnt), 0);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    check(dsp_mode, "R2 sync low enters frame mode", longint'(dsp_mode), 1);

    // sweep: every channel code in both word widths
    for (int w = 0; w < 2; w++) begin
      for (int ch = 0; ch < 8; ch++) begin
        full_frame(w[0], {ch[2:0], 5'(ch * 5 + w * 3)},
                   14'h2A5C ^ 14'(ch * 14'h0731) ^ (w != 0 ? 14'h3FFF : 14'h0000));
      end
    end

    // R9 restart before the sampling point
    send_sync(1'b0);
    run_clocks(8'h5A, 5);
    check(samp_cnt == 0 && got_fs == 0, "R9 no sample before restart", longint'(samp_cnt), 0);
    full_frame(1'b0, 8'h9C, 14'h1234);

    // R9 restart in the middle of the output shift
    result_in = 14'h3FFF;
    send_sync(1'b0);
    run_clocks(8'h33, 20);
    check(got_dout[20] == 1'b1, "R7 all-ones result bit", longint'(got_dout[20]), 1);
    wide_sel = 1'b1;
    fsync_in = 1'b1;
    repeat (6) @(negedge clk);
    fsync_in = 1'b0;
    repeat (4) @(negedge clk);
    check(!dout && !fsync_out, "R9 restart clears outputs", longint'({dout, fsync_out}), 0);
    clear_obs();
    result_in = 14'h0F0F;
    run_clocks(8'hB1, 36);
    check(samp_at == 15 && samp_cnt == 1 && got_fs == (64'd1 << 16), "R9 restarted wide frame",
          longint'(samp_at), 15);
    check(cmd_word == 8'hB1, "R9 restarted command", longint'(cmd_word), longint'(8'hB1));

    // R10 chip-select rise aborts a conversion
    send_sync(1'b1);
    run_clocks(8'h7E, 10);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!dsp_mode && !dout && !fsync_out, "R10 abort clears state",
          longint'({dsp_mode, dout, fsync_out}), 0);
    send_sync(1'b0);
    run_clocks(8'h7E, 20);
    check(acq_cnt + samp_cnt + cmd_cnt == 0 && got_fs == 0 && got_dout == 0,
          "R10 ignored while deselected", longint'(acq_cnt + samp_cnt + cmd_cnt), 0);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    check(dsp_mode, "R10 re-entry with sync low", longint'(dsp_mode), 1);
    clear_obs();
    run_clocks(8'h7E, 20);
    check(acq_cnt + samp_cnt + cmd_cnt == 0 && got_fs == 0, "R10 waits for new sync",
          longint'(acq_cnt + samp_cnt + cmd_cnt), 0);
    full_frame(1'b1, 8'h4D, 14'h2001);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule